// File: doc/BRIEF.md
# Segmented Pipelined Carry Counter

This block is a wide, free-running up-counter built so that no long carry ripple sits between two registers. The count is held as a short low segment plus a row of wider upper segments. The low segment advances on every enabled cycle. Each upper segment advances only on a registered carry flag. That flag is computed one cycle ahead, from whether the segments below it are about to be all ones.

The concatenated segments always read as an ordinary binary count. A terminal flag marks the all-ones value. The total width and the segment widths are parameters. The defaults are a 32-bit count, a 4-bit low segment and 8-bit upper segments. The topmost segment takes whatever width remains.

Top module: `seg_pipe_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes zero on that edge and `termCnt` is low, whatever `countEn` is.
- R2: On each rising edge with `countEn` high and `rst` low, `countVal` becomes its previous value plus one, modulo 2^TOTAL_W.
- R3: On each rising edge with `countEn` low and `rst` low, `countVal` keeps its value, and so does `termCnt`.
- R4: The low field `countVal[LOW_W-1:0]` (bits [3:0] by default) advances on every enabled edge and wraps from 15 to 0.
- R5: The first upper field `countVal[LOW_W +: SEG_W]` (bits [11:4] by default) advances by one on exactly the enabled edge on which the low field wraps from all ones to zero. It is unchanged on every other edge.
- R6: A carry crosses every segment boundary on the same edge, including the boundary into a narrower top segment. From all ones, an enabled edge gives zero.
- R7: `termCnt` is high in exactly those cycles in which every bit of `countVal` is one, including when the count is held there.
- R8: Disabled cycles just before a carry, such as while the low field is at 14 or 15, do not lose or duplicate the pending carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| countEn | input | 1 | Count enable; advances the count by one when high |
| countVal | output | TOTAL_W | Current count, low segment in the least significant bits |
| termCnt | output | 1 | High while the count is all ones |

## Verification
The assertions take `rst` and `countEn` to be known, synchronous levels that are sampled only at rising edges. They also take reset to be asserted from the first edge, so that the carry flags start consistent with a zero count. The stimulus keeps to this by holding reset high from time zero. It changes both inputs only on falling clock edges.

The run uses a 16-bit instance, which splits into segments of 4, 8 and 4 bits. It walks the whole count range, with enable gaps placed just before a carry. It therefore reaches the all-ones value and wraps to zero.

// File: rtl/seg_cnt_pkg.sv
package seg_cnt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;   // synchronous clear of every segment
    logic adv;   // low segment advances this edge
  } segStrobe_t;

  // Number of upper segments; the last one takes the remainder
  function automatic int upperCount(input int totalW, input int lowW, input int segW);
    return (totalW - lowW + segW - 1) / segW;
  endfunction

endpackage

// File: rtl/seg_cnt_dp.sv
module seg_cnt_dp
  import seg_cnt_pkg::*;
#(
  parameter int TOTAL_W = 32,
  parameter int LOW_W   = 4,
  parameter int SEG_W   = 8,
  parameter int NUM_UP  = 4
) (
  input  logic               clk,
  input  segStrobe_t         strobe,
  input  logic [NUM_UP-1:0]  upInc,
  output logic [TOTAL_W-1:0] countVal,
  output logic               lowPreMax,
  output logic [NUM_UP-1:0]  upMax
);

  localparam logic [LOW_W-1:0] LOW_PRE = {{(LOW_W-1){1'b1}}, 1'b0};

  logic [LOW_W-1:0] lowQ;

  always_ff @(posedge clk) begin
    if (strobe.clr)      lowQ <= '0;
    else if (strobe.adv) lowQ <= lowQ + 1'b1;
  end

  assign lowPreMax            = (lowQ == LOW_PRE);
  assign countVal[LOW_W-1:0]  = lowQ;

  for (genvar k = 0; k < NUM_UP; k++) begin : g_up
    localparam int BASE = LOW_W + k * SEG_W;
    localparam int W    = (k == NUM_UP - 1) ? (TOTAL_W - BASE) : SEG_W;

    logic [W-1:0] segQ;

    always_ff @(posedge clk) begin
      if (strobe.clr)    segQ <= '0;
      else if (upInc[k]) segQ <= segQ + 1'b1;
    end

    assign countVal[BASE +: W] = segQ;
    assign upMax[k]            = &segQ;
  end

endmodule

// File: rtl/seg_cnt_ctrl.sv
module seg_cnt_ctrl
  import seg_cnt_pkg::*;
#(
  parameter int NUM_UP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              countEn,
  input  logic              lowPreMax,
  input  logic [NUM_UP-1:0] upMax,
  output segStrobe_t        strobe,
  output logic [NUM_UP-1:0] upInc,
  output logic              termCnt
);

  // lowerFull[k]: after this enabled edge, every segment below upper k is all ones
  logic [NUM_UP-1:0] lowerFull;
  logic [NUM_UP-1:0] carryQ;

  assign lowerFull[0] = lowPreMax;
  for (genvar k = 1; k < NUM_UP; k++) begin : g_full
    assign lowerFull[k] = lowerFull[k-1] & upMax[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst)          carryQ <= '0;
    else if (countEn) carryQ <= lowerFull;
  end

  assign strobe.clr = rst;
  assign strobe.adv = countEn & ~rst;
  assign upInc      = {NUM_UP{strobe.adv}} & carryQ;
  assign termCnt    = carryQ[NUM_UP-1] & upMax[NUM_UP-1];

endmodule

// File: rtl/seg_pipe_counter.sv
module seg_pipe_counter
  import seg_cnt_pkg::*;
#(
  parameter int TOTAL_W = 32,
  parameter int LOW_W   = 4,
  parameter int SEG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               countEn,
  output logic [TOTAL_W-1:0] countVal,
  output logic               termCnt
);

  localparam int NUM_UP = upperCount(TOTAL_W, LOW_W, SEG_W);

  segStrobe_t        strobe;
  logic [NUM_UP-1:0] upInc;
  logic [NUM_UP-1:0] upMax;
  logic              lowPreMax;

  seg_cnt_ctrl #(.NUM_UP(NUM_UP)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .countEn   (countEn),
    .lowPreMax (lowPreMax),
    .upMax     (upMax),
    .strobe    (strobe),
    .upInc     (upInc),
    .termCnt   (termCnt)
  );

  seg_cnt_dp #(
    .TOTAL_W (TOTAL_W),
    .LOW_W   (LOW_W),
    .SEG_W   (SEG_W),
    .NUM_UP  (NUM_UP)
  ) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .upInc     (upInc),
    .countVal  (countVal),
    .lowPreMax (lowPreMax),
    .upMax     (upMax)
  );

endmodule

// File: rtl/seg_pipe_counter_chk.sv
module seg_pipe_counter_chk #(
  parameter int TOTAL_W = 32,
  parameter int LOW_W   = 4,
  parameter int SEG_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               countEn,
  input logic [TOTAL_W-1:0] countVal,
  input logic               termCnt
);

  localparam int FW = (SEG_W < TOTAL_W - LOW_W) ? SEG_W : (TOTAL_W - LOW_W);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (countVal == '0) && !termCnt);

  assert_enabled_step_R2: assert property (@(posedge clk) disable iff (rst)
    countEn |=> countVal == $past(countVal) + 1'b1);

  assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !countEn |=> $stable(countVal) && $stable(termCnt));

  assert_carry_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (countEn && countVal[LOW_W-1:0] == '1) |=>
      countVal[LOW_W +: FW] == $past(countVal[LOW_W +: FW]) + 1'b1);

  assert_no_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (countVal[LOW_W-1:0] != '1) |=> $stable(countVal[LOW_W +: FW]));

  assert_terminal_R7: assert property (@(posedge clk) disable iff (rst)
    termCnt == (countVal == '1));

endmodule

bind seg_pipe_counter seg_pipe_counter_chk #(
  .TOTAL_W (TOTAL_W),
  .LOW_W   (LOW_W),
  .SEG_W   (SEG_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .countEn  (countEn),
  .countVal (countVal),
  .termCnt  (termCnt)
);

// File: tb/seg_pipe_counter_bench.sv
module seg_pipe_counter_bench;

  localparam int W = 16;

  typedef struct packed {
    logic        en;
    logic [15:0] exp;
  } vec_t;

  // Enable pattern from reset, gaps placed around the first carry (R8)
  localparam vec_t TBL [22] = '{
    '{1'b1, 16'd1},  '{1'b1, 16'd2},  '{1'b1, 16'd3},  '{1'b1, 16'd4},
    '{1'b1, 16'd5},  '{1'b1, 16'd6},  '{1'b1, 16'd7},  '{1'b1, 16'd8},
    '{1'b1, 16'd9},  '{1'b1, 16'd10}, '{1'b1, 16'd11}, '{1'b1, 16'd12},
    '{1'b1, 16'd13}, '{1'b0, 16'd13}, '{1'b1, 16'd14}, '{1'b0, 16'd14},
    '{1'b0, 16'd14}, '{1'b1, 16'd15}, '{1'b0, 16'd15}, '{1'b1, 16'd16},
    '{1'b1, 16'd17}, '{1'b0, 16'd17}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         countEn = 1'b0;
  logic [W-1:0] countVal;
  logic         termCnt;
  logic [W-1:0] model;
  int           nChecks = 0;
  int           nFail = 0;

  seg_pipe_counter #(.TOTAL_W(W), .LOW_W(4), .SEG_W(8)) u_seg_pipe_counter (
    .clk      (clk),
    .rst      (rst),
    .countEn  (countEn),
    .countVal (countVal),
    .termCnt  (termCnt)
  );

  always #5 clk = ~clk;

  // Plain behavioural reference counter
  always @(posedge clk) begin
    if (rst)          model <= '0;
    else if (countEn) model <= model + 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives enable and samples at the next falling edge
  task automatic step(input logic en);
    countEn = en;
    @(negedge clk);
    check("R2 count vs reference", 32'(countVal), 32'(model));
    check("R7 terminal flag", 32'(termCnt), 32'(model == '1));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset count", 32'(countVal), 32'd0);
    check("R1 reset terminal", 32'(termCnt), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < 22; i++) begin
      step(TBL[i].en);
      check("R4/R8 table count", 32'(countVal), 32'(TBL[i].exp));
      check("R4 low field", 32'(countVal[3:0]), 32'(TBL[i].exp[3:0]));
      if (TBL[i].exp == 16'd16 && TBL[i].en)
        check("R5 upper field on low wrap", 32'(countVal[11:4]), 32'd1);
    end

    while (model != 16'h0FFF) step(1'b1);
    step(1'b1);
    check("R6 carry into top segment", 32'(countVal), 32'h1000);

    while (model != 16'hFFFE) step(1'b1);
    step(1'b1);
    check("R7 all ones value", 32'(countVal), 32'hFFFF);
    check("R7 terminal at all ones", 32'(termCnt), 32'd1);

    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      check("R3 hold at all ones", 32'(countVal), 32'hFFFF);
      check("R3 terminal held", 32'(termCnt), 32'd1);
    end

    step(1'b1);
    check("R6 wrap to zero", 32'(countVal), 32'd0);
    check("R7 terminal after wrap", 32'(termCnt), 32'd0);

    for (int i = 0; i < 5; i++) step(1'b1);
    check("R2 count after wrap", 32'(countVal), 32'd5);
    rst = 1'b1;
    countEn = 1'b1;
    @(negedge clk);
    check("R1 reset with enable high", 32'(countVal), 32'd0);
    check("R1 terminal in reset", 32'(termCnt), 32'd0);
    rst = 1'b0;
    step(1'b1);
    check("R1 count resumes after reset", 32'(countVal), 32'd1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule